// File: doc/BRIEF.md
# Wide ADC Rate-Halving Lane Demultiplexer

This block takes a wide parallel word from a fast analogue-to-digital front end, sixteen 8-bit samples in each cycle of the capture clock. It splits the word into sixteen lanes. Each lane pairs two successive samples into one 16-bit word and queues it in a FIFO of its own. A read clock at half the capture rate empties all sixteen FIFOs in lock-step. The block then groups the lanes in twos, so that each of eight downstream complex transform engines gets one real stream on its real input and an unrelated real stream on its imaginary input (f = a + j·b).

The two clock domains are asynchronous. Each FIFO carries its pointers across in gray code. A write that finds any FIFO full is dropped, and it sets a sticky error flag in the capture domain. Reads begin only when every lane holds at least one word, so the sixteen streams stay aligned. A single valid strobe serves all eight engines.

Top module: `adc_lane_pair_demux`

## Requirements
- R1: While `rd_rst` is high, `out_valid` is 0. After `wr_rst` has been high, `ovf_err` is 0 until the next overflow.
- R2: Each engine port carries a 16-bit word built from two samples of one lane: the sample captured first is in bits [7:0] and the sample captured second is in bits [15:8].
- R3: Engine k (k = 0..7) takes lane 2k on `out_re[16k+15:16k]` and lane 2k+1 on `out_im[16k+15:16k]`. Lane l is `in_data[8l+7:8l]`.
- R4: `out_valid` is a single strobe for all eight engines. Each cycle in which it is high delivers exactly one new word per lane. It is never high without a pending pair.
- R5: With no overflow, every completed sample pair comes out exactly once and in capture order, with none lost or repeated.
- R6: No output appears until every lane has a complete pair queued. A lone unpaired sample never produces `out_valid`.
- R7: A completed pair that arrives while any lane FIFO is full sets `ovf_err`. The flag stays at 1 until `wr_rst`.
- R8: Capture cycles with `in_valid` low are ignored. Pairing counts only valid cycles, so gaps between the two samples of a pair do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Fast capture clock |
| wr_rst | input | 1 | Synchronous active-high reset, capture domain |
| in_valid | input | 1 | Marks a valid capture word |
| in_data | input | 128 | Sixteen 8-bit samples, lane l at bits [8l+7:8l] |
| ovf_err | output | 1 | Sticky FIFO overflow flag, capture domain |
| rd_clk | input | 1 | Half-rate read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_valid | output | 1 | Common strobe for all eight engines |
| out_re | output | 128 | Real-port words, engine k at bits [16k+15:16k] |
| out_im | output | 128 | Imaginary-port words, engine k at bits [16k+15:16k] |

## Verification
The bench sends a single sample and waits. A design that paired the wrong way, or began reads before a full word was queued, would then emit a word. Distinct per-lane, per-index sample values expose any swapped byte order, crossed real/imaginary lanes or wrong engine index as a data mismatch against the scoreboard. Gapped input checks that idle capture cycles do not advance the pairing phase. A stalled read side drives the FIFOs full, which checks that the overflow flag rises and then stays set until reset.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

    localparam int SAMPLE_W   = 8;
    localparam int NUM_LANES  = 16;
    localparam int FIFO_DEPTH = 8;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pack_phase_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/lane_packer.sv
module lane_packer
    import adc_demux_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int SW    = SAMPLE_W,
    localparam int WW   = 2 * SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LANES*SW-1:0] in_data,
    output logic              word_valid,
    output logic [LANES*WW-1:0] word_data
);

    pack_phase_e           phase;
    logic [LANES*SW-1:0]   held;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_FIRST;
            word_valid <= 1'b0;
        end else begin
            word_valid <= in_valid && (phase == PH_SECOND);
            if (in_valid) begin
                phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && phase == PH_FIRST) begin
            held <= in_data;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (in_valid && phase == PH_SECOND) begin
                word_data[l*WW +: WW] <= {in_data[l*SW +: SW], held[l*SW +: SW]};
            end
        end
    end

endmodule

// File: rtl/async_word_fifo.sv
module async_word_fifo
    import adc_demux_pkg::*;
#(
    parameter int W     = 2 * SAMPLE_W,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic         wr_clk,
    input  logic         wr_rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_clk,
    input  logic         rd_rst,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);

    logic [W-1:0]  mem [DEPTH];

    logic [PW-1:0] wbin, wgray, rq1, rq2;
    logic [PW-1:0] rbin, rgray, wq1, wq2;
    logic [PW-1:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + PW'(1);
    assign rbin_nx = rbin + PW'(1);

    // full when write gray equals read gray with the two top bits inverted
    assign full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    assign empty = (rgray == wq2);

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wbin  <= '0;
            wgray <= '0;
            rq1   <= '0;
            rq2   <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
            if (wr_en && !full) begin
                wbin  <= wbin_nx;
                wgray <= PW'(bin_to_gray(32'(wbin_nx)));
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) begin
            mem[wbin[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            if (rd_en && !empty) begin
                rbin  <= rbin_nx;
                rgray <= PW'(bin_to_gray(32'(rbin_nx)));
            end
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_en && !empty) begin
            rd_data <= mem[rbin[AW-1:0]];
        end
    end

endmodule

// File: rtl/engine_pairer.sv
module engine_pairer
    import adc_demux_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int WW    = 2 * SAMPLE_W,
    localparam int ENG  = LANES / 2
) (
    input  logic [LANES*WW-1:0] lane_words,
    output logic [ENG*WW-1:0]   re_words,
    output logic [ENG*WW-1:0]   im_words
);

    for (genvar k = 0; k < ENG; k++) begin : g_eng
        assign re_words[k*WW +: WW] = lane_words[(2*k)*WW   +: WW];
        assign im_words[k*WW +: WW] = lane_words[(2*k+1)*WW +: WW];
    end

endmodule

// File: rtl/adc_lane_pair_demux.sv
module adc_lane_pair_demux
    import adc_demux_pkg::*;
#(
    parameter int SW    = SAMPLE_W,
    parameter int LANES = NUM_LANES,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int WW   = 2 * SW,
    localparam int ENG  = LANES / 2
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic                in_valid,
    input  logic [LANES*SW-1:0] in_data,
    output logic                ovf_err,
    input  logic                rd_clk,
    input  logic                rd_rst,
    output logic                out_valid,
    output logic [ENG*WW-1:0]   out_re,
    output logic [ENG*WW-1:0]   out_im
);

    logic                  word_valid;
    logic [LANES*WW-1:0]   word_data;
    logic [LANES*WW-1:0]   lane_words;
    logic [LANES-1:0]      lane_full, lane_empty;
    logic                  pop;

    lane_packer #(.LANES(LANES), .SW(SW)) u_packer (
        .clk        (wr_clk),
        .rst        (wr_rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_fifo
        async_word_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
            .wr_clk  (wr_clk),
            .wr_rst  (wr_rst),
            .wr_en   (word_valid),
            .wr_data (word_data[l*WW +: WW]),
            .full    (lane_full[l]),
            .rd_clk  (rd_clk),
            .rd_rst  (rd_rst),
            .rd_en   (pop),
            .rd_data (lane_words[l*WW +: WW]),
            .empty   (lane_empty[l])
        );
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            ovf_err <= 1'b0;
        end else if (word_valid && |lane_full) begin
            ovf_err <= 1'b1;
        end
    end

    // read only when every lane has a word, keeping lanes aligned
    assign pop = ~|lane_empty;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= pop;
        end
    end

    engine_pairer #(.LANES(LANES), .WW(WW)) u_pairer (
        .lane_words (lane_words),
        .re_words   (out_re),
        .im_words   (out_im)
    );

endmodule

// File: rtl/adc_demux_checker.sv
module adc_demux_checker (
    input logic wr_clk,
    input logic wr_rst,
    input logic in_valid,
    input logic ovf_err,
    input logic rd_clk,
    input logic rd_rst,
    input logic out_valid
);

    logic [31:0] wr_samples;
    logic [31:0] rd_words;

    always_ff @(posedge wr_clk) begin
        if (wr_rst)        wr_samples <= '0;
        else if (in_valid) wr_samples <= wr_samples + 32'd1;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)         rd_words <= '0;
        else if (out_valid) rd_words <= rd_words + 32'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge rd_clk)
        rd_rst |=> !out_valid);                                   // R1

    AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
        ovf_err |=> ovf_err);                                     // R7

    AST_OVF_CAUSE: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(ovf_err) |-> wr_samples >= 32'd2);                  // R7

    AST_NO_EARLY_OUT: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        out_valid |-> ((rd_words + 32'd1) * 32'd2 <= wr_samples)); // R6

    AST_NO_OUT_WITHOUT_PAIR: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        out_valid |-> wr_samples >= 32'd2);                       // R4

endmodule

bind adc_lane_pair_demux adc_demux_checker u_chk (
    .wr_clk    (wr_clk),
    .wr_rst    (wr_rst),
    .in_valid  (in_valid),
    .ovf_err   (ovf_err),
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .out_valid (out_valid)
);

// File: tb/adc_lane_pair_demux_test.sv
module adc_lane_pair_demux_test;

    localparam int SW    = 8;
    localparam int LANES = 16;
    localparam int DEPTH = 8;
    localparam int WW    = 2 * SW;
    localparam int ENG   = LANES / 2;

    typedef struct packed {
        logic [ENG*WW-1:0] re;
        logic [ENG*WW-1:0] im;
    } exp_t;

    logic                wr_clk = 1'b0;
    logic                rd_clk = 1'b0;
    logic                wr_rst, rd_rst, in_valid;
    logic [LANES*SW-1:0] in_data;
    logic                ovf_err, out_valid;
    logic [ENG*WW-1:0]   out_re, out_im;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   gidx  = 0;
    bit   bphase = 1'b0;
    bit   record = 1'b1;
    logic [LANES*SW-1:0] first_word;
    exp_t q[$];

    always #5  wr_clk = ~wr_clk;   // 100 MHz capture clock
    always #10 rd_clk = ~rd_clk;   // half-rate read clock

    adc_lane_pair_demux uut (
        .wr_clk    (wr_clk),
        .wr_rst    (wr_rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .ovf_err   (ovf_err),
        .rd_clk    (rd_clk),
        .rd_rst    (rd_rst),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    function automatic logic [SW-1:0] samp(int lane, int idx);
        return SW'((lane * 37 + idx * 11 + 5) & 8'hff);
    endfunction

    task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: one valid capture per call, expected item pushed when a pair closes
    task automatic send(int n, bit gap);
        for (int i = 0; i < n; i++) begin
            logic [LANES*SW-1:0] w;
            for (int l = 0; l < LANES; l++) w[l*SW +: SW] = samp(l, gidx);
            @(negedge wr_clk);
            in_valid = 1'b1;
            in_data  = w;
            if (bphase) begin
                exp_t e;
                for (int k = 0; k < ENG; k++) begin
                    e.re[k*WW +: WW] = {w[(2*k)*SW +: SW],   first_word[(2*k)*SW +: SW]};
                    e.im[k*WW +: WW] = {w[(2*k+1)*SW +: SW], first_word[(2*k+1)*SW +: SW]};
                end
                if (record) q.push_back(e);
            end else begin
                first_word = w;
            end
            bphase = ~bphase;
            gidx++;
            if (gap) begin
                @(negedge wr_clk);
                in_valid = 1'b0;
                in_data  = '1;           // junk on idle cycles (R8)
                @(negedge wr_clk);
            end
        end
        @(negedge wr_clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge rd_clk);
        repeat (6) @(negedge rd_clk);
        check(q.size() == 0, "R5", "pending pairs not delivered", 256'(q.size()), 256'd0);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge rd_clk) begin
        if (out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R4", "out_valid with no pending pair", 256'd1, 256'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_re === e.re, "R2/R3", "real-port words", 256'(out_re), 256'(e.re));
                check(out_im === e.im, "R2/R3", "imag-port words", 256'(out_im), 256'(e.im));
            end
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "WDOG", "watchdog expired", 256'd0, 256'd1);
        finish_run();
    end

    initial begin
        wr_rst = 1'b1; rd_rst = 1'b1; in_valid = 1'b0; in_data = '0;
        repeat (4) @(negedge wr_clk);
        check(out_valid === 1'b0, "R1", "out_valid in reset", 256'(out_valid), 256'd0);
        check(ovf_err === 1'b0, "R1", "ovf_err after reset", 256'(ovf_err), 256'd0);
        @(negedge wr_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;

        // R6: a lone sample must not surface
        send(1, 1'b0);
        for (int i = 0; i < 12; i++) begin
            @(negedge rd_clk);
            check(out_valid === 1'b0, "R6", "output from unpaired sample", 256'(out_valid), 256'd0);
        end
        // completing the pair releases one word (R2, R3)
        send(1, 1'b0);
        drain();

        // R5: contiguous burst at full rate
        send(24, 1'b0);
        drain();

        // R8: gapped capture, pairing counts valid cycles only
        send(9, 1'b1);
        send(1, 1'b0);
        drain();
        check(ovf_err === 1'b0, "R7", "no overflow in normal flow", 256'(ovf_err), 256'd0);

        // R7: stall read side, overfill
        @(negedge wr_clk);
        rd_rst = 1'b1;
        record = 1'b0;
        send(2 * (DEPTH + 2), 1'b0);
        repeat (2) @(negedge wr_clk);
        check(ovf_err === 1'b1, "R7", "overflow flag set", 256'(ovf_err), 256'd1);
        check(out_valid === 1'b0, "R1", "out_valid while read reset", 256'(out_valid), 256'd0);
        repeat (8) @(negedge wr_clk);
        check(ovf_err === 1'b1, "R7", "overflow flag sticky", 256'(ovf_err), 256'd1);

        // clear both domains
        wr_rst = 1'b1;
        repeat (4) @(negedge rd_clk);
        check(ovf_err === 1'b0, "R1", "ovf_err cleared by reset", 256'(ovf_err), 256'd0);
        @(negedge wr_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;
        record = 1'b1; bphase = 1'b0;
        q.delete();

        // traffic after recovery
        send(6, 1'b0);
        drain();

        finish_run();
    end

endmodule